// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received Ethernet frames from a switch fabric and places them in host memory. Software prepares a circular ring of four-word descriptors. Each descriptor names a buffer and its length and carries an ownership flag. For each frame the block claims the next descriptor, stores the frame bytes in its buffer and writes a completion status word. It then hands the descriptor back to software by clearing the ownership flag.

Frames arrive one byte at a time with start and end markers. The end byte also carries the ingress port number and an FCS-error flag. All memory traffic uses a single word-wide request/grant master. Software sees three registers: the ring base, a sticky interrupt status, and an interrupt mask. Completed frames raise a receive-done interrupt. Running out of descriptors raises a ring-full interrupt, and the frame is discarded.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset the block is idle. `rx_ready`, `mem_req` and `irq` are low, and the status register reads 0.
- R2: Descriptor word 0 (offset 0) holds the ownership flag in bit 31, the ring-end flag in bit 28 and the buffer address in bits 27:0. On completion the block rewrites word 0 with bit 31 cleared and bits 30:0 unchanged.
- R3: Frame bytes are packed little-endian. Byte i of a frame is stored at buffer address + i, so byte lane i mod 4 of word i/4 holds it.
- R4: The block writes the status word at descriptor offset 12. Bits 26:16 hold the count of stored bytes, FCS included. Bits 14:12 hold the ingress port. Bit 1 is the oversize flag and bit 0 the FCS-error flag. All other bits are 0.
- R5: After the descriptor whose ring-end flag is set, the next descriptor is the one at the ring base. Otherwise the next descriptor sits 16 bytes further on.
- R6: Bits 10:0 of descriptor word 2 (offset 8) give the buffer length in bytes. Bytes beyond that length are not written, and the oversize flag is set.
- R7: If the fetched descriptor has bit 31 clear, the whole frame is consumed without any memory write. Status bit 1 (ring full) is set, and the ring index does not advance.
- R8: Status bit 0 (receive done) is set after each completed frame.
- R9: Writing the status register clears each bit written as 1. Bits written as 0 keep their value.
- R10: `irq` is high exactly when some status bit is set whose mask bit is 0. A masked source still sets its status bit.
- R11: The registers sit at index 0 (ring base, bits 3:0 forced to 0), index 1 (status, bits 1:0) and index 2 (mask, bits 1:0). Each reads back through `reg_rdata`.
- R12: A memory request keeps its address, direction and write data unchanged until `mem_gnt` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt output |
| rx_valid | input | 1 | Frame byte valid |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_data | input | 8 | Frame byte |
| rx_port | input | 3 | Ingress port, sampled with the last byte |
| rx_fcs_err | input | 1 | FCS error, sampled with the last byte |
| rx_ready | output | 1 | Byte accepted when high with rx_valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_gnt on a read |

## Verification
The receive-done bit rises one clock after the grant of the ownership-clearing write. That write lands in memory on the same edge. The bench polls the status register on falling edges and inspects memory only after it sees the bit, so the due cycle is never guessed.

The ring-full bit is set on the edge that grants the descriptor fetch. That edge comes before the frame's first byte is taken, so the bit is present once the whole frame has been pushed. `irq` is a direct function of two registers. It is checked on the falling edge after each register write, and the grant line stalls every other cycle for most frames.

// File: rtl/rx_ring_dma.sv
module rx_ring_dma #(
  parameter int IDX_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [7:0]  rx_data,
  input  logic [2:0]  rx_port,
  input  logic        rx_fcs_err,
  output logic        rx_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic [31:0] mem_rdata
);
  localparam logic [2:0] S_IDLE = 3'd0, S_FA = 3'd1, S_FL = 3'd2, S_RX = 3'd3,
                         S_WD = 3'd4, S_WS = 3'd5, S_WA = 3'd6, S_DROP = 3'd7;

  logic [2:0]       state;
  logic [31:0]      base_q;
  logic [1:0]       stat_q, mask_q, set_v, clr_v;
  logic [IDX_W-1:0] idx;
  logic [30:0]      w0_q;
  logic [10:0]      buflen;
  logic [11:0]      cnt;
  logic [9:0]       wptr;
  logic [31:0]      wbuf;
  logic             pend, last, ovf, fcs;
  logic [2:0]       port;

  wire [31:0] desc = base_q + {{(28-IDX_W){1'b0}}, idx, 4'b0000};
  wire        room = cnt < {1'b0, buflen};
  wire [1:0]  lane = cnt[1:0];

  assign rx_ready = (state == S_RX) || (state == S_DROP);
  assign irq      = |(stat_q & ~mask_q);
  assign set_v    = {state == S_FA && mem_gnt && !mem_rdata[31], state == S_WA && mem_gnt};
  assign clr_v    = (reg_wr && reg_addr == 2'd1) ? reg_wdata[1:0] : 2'b00;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = base_q;
      2'd1:    reg_rdata = {30'd0, stat_q};
      2'd2:    reg_rdata = {30'd0, mask_q};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc;
    mem_wdata = 32'd0;
    case (state)
      S_FA: mem_req = 1'b1;
      S_FL: begin mem_req = 1'b1; mem_addr = desc + 32'd8; end
      S_WD: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {4'd0, w0_q[27:0]} + {20'd0, wptr, 2'b00};
        mem_wdata = wbuf;
      end
      S_WS: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc + 32'd12;
        mem_wdata = {5'd0, cnt[10:0], 1'b0, port, 10'd0, ovf, fcs};
      end
      S_WA: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {1'b0, w0_q};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      base_q <= '0;
      stat_q <= '0;
      mask_q <= '0;
      idx    <= '0;
      w0_q   <= '0;
      buflen <= '0;
      cnt    <= '0;
      wptr   <= '0;
      wbuf   <= '0;
      pend   <= 1'b0;
      last   <= 1'b0;
      ovf    <= 1'b0;
      fcs    <= 1'b0;
      port   <= '0;
    end else begin
      if (reg_wr && reg_addr == 2'd0) base_q <= {reg_wdata[31:4], 4'b0000};
      if (reg_wr && reg_addr == 2'd2) mask_q <= reg_wdata[1:0];
      stat_q <= (stat_q & ~clr_v) | set_v;
      case (state)
        S_IDLE: if (rx_valid && rx_sof) state <= S_FA;
        S_FA: if (mem_gnt) begin
          if (mem_rdata[31]) begin
            w0_q  <= mem_rdata[30:0];
            state <= S_FL;
          end else begin
            state <= S_DROP;
          end
        end
        S_FL: if (mem_gnt) begin
          buflen <= mem_rdata[10:0];
          cnt    <= '0;
          wbuf   <= '0;
          pend   <= 1'b0;
          last   <= 1'b0;
          ovf    <= 1'b0;
          state  <= S_RX;
        end
        S_RX: if (rx_valid) begin
          if (rx_eof) begin
            last <= 1'b1;
            port <= rx_port;
            fcs  <= rx_fcs_err;
          end
          if (room) begin
            wbuf[{lane, 3'b000} +: 8] <= rx_data;
            cnt  <= cnt + 12'd1;
            wptr <= cnt[11:2];
            if (lane == 2'd3 || rx_eof) state <= S_WD;
            else pend <= 1'b1;
          end else begin
            ovf <= 1'b1;
            if (rx_eof) state <= pend ? S_WD : S_WS;
          end
        end
        S_WD: if (mem_gnt) begin
          wbuf  <= '0;
          pend  <= 1'b0;
          state <= last ? S_WS : S_RX;
        end
        S_WS: if (mem_gnt) state <= S_WA;
        S_WA: if (mem_gnt) begin
          idx   <= w0_q[28] ? '0 : idx + 1'b1;
          state <= S_IDLE;
        end
        S_DROP: if (rx_valid && rx_eof) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_dma_chk.sv
module rx_ring_dma_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_gnt,
  input logic [31:0]      mem_addr,
  input logic [31:0]      mem_wdata,
  input logic             rx_ready,
  input logic [2:0]       state,
  input logic [1:0]       stat_q,
  input logic [IDX_W-1:0] idx,
  input logic [11:0]      cnt,
  input logic [10:0]      buflen
);
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_ready_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !mem_req);

  p_own_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd6 && mem_req) |-> (mem_we && !mem_wdata[31]));

  p_done_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd6 && mem_gnt) |=> stat_q[0]);

  p_len_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= {1'b0, buflen});

  p_drop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd7 |=> $stable(idx));
endmodule

bind rx_ring_dma rx_ring_dma_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rx_ready(rx_ready), .state(state),
  .stat_q(stat_q), .idx(idx), .cnt(cnt), .buflen(buflen)
);

// File: tb/rx_ring_dma_tb.sv
module rx_ring_dma_tb;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 2'd1;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_fcs_err = 0, rx_ready;
  logic [7:0] rx_data = 0;
  logic [2:0] rx_port = 0;
  logic mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] mem [0:255];
  int total = 0, bad = 0, cyc = 0, wr_cnt = 0;
  logic stall_on = 0;

  localparam int NV = 4;
  localparam int LEN  [NV] = '{10, 7, 12, 6};
  localparam int PORT [NV] = '{2, 5, 1, 3};
  localparam int FCS  [NV] = '{0, 1, 0, 0};
  localparam int DSC  [NV] = '{0, 1, 2, 0};
  localparam int DROP [NV] = '{0, 0, 0, 1};
  localparam int BL   [3]  = '{64, 64, 8};
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;

  always #2.5 clk = ~clk;

  rx_ring_dma u_dut (.*);

  assign mem_gnt   = stall_on ? cyc[0] : 1'b1;
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_we && mem_gnt) begin
      mem[mem_addr[9:2]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  always @(posedge clk) if (cyc > 100000) begin
    bad = bad + 1;
    total = total + 1;
    $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_addr = 2'd1;
  endtask

  function automatic logic [7:0] fbyte(input int seed, input int k);
    return 8'(seed * 37 + k + 1);
  endfunction

  function automatic logic [7:0] mbyte(input int a);
    logic [31:0] w;
    w = mem[a >> 2];
    return w[(a % 4) * 8 +: 8];
  endfunction

  task automatic push(input logic [7:0] d, input bit s, input bit e);
    rx_valid = 1; rx_data = d; rx_sof = s; rx_eof = e;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send(input int len, input int prt, input int fe, input int seed);
    rx_port = 3'(prt); rx_fcs_err = 1'(fe);
    for (int k = 0; k < len; k++) push(fbyte(seed, k), k == 0, k == len - 1);
    rx_valid = 0; rx_sof = 0; rx_eof = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int t = 0; t < 400 && !ok; t++) begin
      if (reg_rdata[0]) ok = 1;
      else @(negedge clk);
    end
  endtask

  task automatic check_frame(input int d, input int len, input int prt, input int fe, input int seed, input string req);
    int stored, ovf, da, ba, exp_st, errs;
    stored = len > BL[d] ? BL[d] : len;
    ovf = len > BL[d] ? 1 : 0;
    da = 'h40 + 16 * d;
    ba = 'h100 + 'h40 * d;
    exp_st = (stored << 16) | (prt << 12) | (ovf << 1) | fe;
    chk(mem[(da + 12) >> 2] == 32'(exp_st), req, "R4 status word", mem[(da + 12) >> 2], exp_st);
    chk(mem[da >> 2] == ((d == 2) ? 32'h1000_0180 : 32'(ba)), "R2", "owner word", mem[da >> 2],
        (d == 2) ? 32'h1000_0180 : ba);
    errs = 0;
    for (int k = 0; k < stored; k++) if (mbyte(ba + k) != fbyte(seed, k)) errs++;
    chk(errs == 0, "R3", "payload byte mismatches", errs, 0);
  endtask

  initial begin
    bit ok;
    int wsave;
    for (int i = 0; i < 256; i++) mem[i] = SENT;
    mem['h40 >> 2] = 32'h8000_0100; mem['h48 >> 2] = 64;
    mem['h50 >> 2] = 32'h8000_0140; mem['h58 >> 2] = 64;
    mem['h60 >> 2] = 32'h9000_0180; mem['h68 >> 2] = 8;
    repeat (3) @(negedge clk);
    chk(!rx_ready && !mem_req && !irq, "R1", "idle outputs in reset", {rx_ready, mem_req, irq}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(reg_rdata == 0, "R1", "status after reset", reg_rdata, 0);
    chk(!irq && !mem_req, "R1", "irq/req after reset", {irq, mem_req}, 0);

    wreg(2'd0, 32'h4C);
    reg_addr = 2'd0; #1;
    chk(reg_rdata == 32'h40, "R11", "base readback", reg_rdata, 32'h40);
    wreg(2'd2, 32'h3);
    reg_addr = 2'd2; #1;
    chk(reg_rdata == 32'h3, "R11", "mask readback", reg_rdata, 3);
    wreg(2'd2, 0);

    for (int i = 0; i < NV; i++) begin
      stall_on = (i != 0);
      wsave = wr_cnt;
      send(LEN[i], PORT[i], FCS[i], i);
      if (DROP[i] != 0) begin
        repeat (2) @(negedge clk);
        chk(reg_rdata[1:0] == 2'b10, "R7", "ring-full status", reg_rdata, 2);
        chk(wr_cnt == wsave, "R7", "writes during drop", wr_cnt, wsave);
        chk(irq, "R10", "irq on ring full", irq, 1);
      end else begin
        wait_done(ok);
        chk(ok, "R8", "done bit after frame", reg_rdata, 1);
        check_frame(DSC[i], LEN[i], PORT[i], FCS[i], i, (i == 2) ? "R6" : "R4");
        if (i == 2) chk(mem['h188 >> 2] == SENT, "R6", "word past buffer", mem['h188 >> 2], SENT);
        wreg(2'd1, 1);
        chk(reg_rdata[0] == 0, "R9", "done cleared by W1C", reg_rdata, 0);
      end
    end

    wreg(2'd1, 0);
    chk(reg_rdata[1:0] == 2'b10, "R9", "zero write keeps full bit", reg_rdata, 2);
    wreg(2'd1, 2);
    chk(reg_rdata == 0 && !irq, "R9", "full bit cleared", reg_rdata, 0);

    mem['h40 >> 2] = 32'h8000_0100;
    mem['h4C >> 2] = SENT;
    send(5, 7, 0, 9);
    wait_done(ok);
    chk(ok, "R5", "frame after wrap completes", reg_rdata, 1);
    check_frame(0, 5, 7, 0, 9, "R5");
    chk(mem['h5C >> 2] == 32'h0007_5001, "R7", "index held: desc1 untouched", mem['h5C >> 2], 32'h0007_5001);
    wreg(2'd1, 1);

    wreg(2'd2, 1);
    mem['h50 >> 2] = 32'h8000_0140;
    send(4, 0, 0, 11);
    wait_done(ok);
    @(negedge clk);
    chk(ok && reg_rdata[0], "R10", "masked source latches", reg_rdata, 1);
    chk(!irq, "R10", "masked irq low", irq, 0);
    check_frame(1, 4, 0, 0, 11, "R4");
    wreg(2'd2, 0);
    chk(irq, "R10", "irq after unmask", irq, 1);
    wreg(2'd1, 1);
    chk(!irq && reg_rdata == 0, "R9", "irq clears with status", irq, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule